// File: doc/BRIEF.md
# Debug Breakpoint Address Matcher

This block sits beside a processor core and watches its 24-bit address bus for a debug controller. It has two independent comparators. Each one holds a 24-bit match value written one byte at a time, an enable bit, and a page-mode bit. When page mode is set, the comparator ignores the low address byte, so any access inside a 256-byte page hits. A single-step control requests a break each time the core reports that an instruction has completed.

Any hit from the two comparators, together with the single-step request, sets one registered break flag. The flag stays high until the debug controller pulses the clear input. Address compares count only in cycles where the address strobe is high. A compare always uses the register contents as they stood before any write in the same cycle.

Top module: `addr_bkpt`

## Requirements
- R1: After reset `brk_o` is 0, and all match bytes, enables, page bits and the single-step bit are 0. With these values no address and no instruction completion raises a break.
- R2: With its enable set and its page bit clear, comparator N sets the break when `addr_i[23:0]` equals its full 24-bit match value {upper, high, low}. Any other address does not set it.
- R3: With its enable set and its page bit set, comparator N compares only `addr_i[23:8]` with {upper, high}. Any low byte then hits.
- R4: A comparator whose enable bit is 0 never sets the break.
- R5: The two comparators are independent. Each uses only its own match bytes, its own enable and its own page bit.
- R6: When the single-step bit is 1, a cycle with `insn_done_i` high sets the break. When the single-step bit is 0, `insn_done_i` has no effect.
- R7: An address compare counts only in cycles where `addr_vld_i` is 1.
- R8: `brk_o` is registered and rises one cycle after a hit. It holds until a cycle with `brk_clr_i` high and no new hit, and then falls in the next cycle. A hit in the same cycle as a clear keeps it high.
- R9: If a register write and a compare happen in the same cycle, the compare uses the value the register held before the write.
- R10: Register select map on `wr_sel_i`: 0, 1 and 2 are the low, high and upper bytes of comparator 0. 3, 4 and 5 are the same bytes of comparator 1. 6 is control. Control bit 0 is single-step. Bit 1 is the page bit of comparator 0 and bit 2 is the page bit of comparator 1. Bit 3 enables comparator 0 and bit 4 enables comparator 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Monitored address bus |
| addr_vld_i | input | 1 | Address strobe that qualifies compares |
| insn_done_i | input | 1 | Instruction completion strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | 8 | Register write data |
| brk_clr_i | input | 1 | Clear pulse for the break flag |
| brk_o | output | 1 | Sticky break request |

## Verification
A wrong match byte, a misplaced control bit, or a page mask on the wrong comparator shows up one cycle after the first qualified address. At that point `brk_o` either rises when it should not or fails to rise. A broken hold or clear path shows up in the cycle after the idle or clear stimulus. A compare that reads the value just written shows up in the one cycle where a write and a matching address coincide. The bench therefore predicts `brk_o` for every single cycle it drives.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  parameter int ADDR_W  = 24;
  parameter int BYTE_W  = 8;
  parameter int NUM_CMP = 2;

  localparam int NBYTES   = ADDR_W / BYTE_W;
  localparam int CTRL_SEL = NUM_CMP * NBYTES;
  localparam int SEL_W    = $clog2(CTRL_SEL + 1);
  // control layout: step, page bits, enable bits
  localparam int STEP_BIT = 0;
  localparam int IGN_LSB  = 1;
  localparam int EN_LSB   = IGN_LSB + NUM_CMP;
  localparam int CTRL_W   = EN_LSB + NUM_CMP;
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [SEL_W-1:0]                  wr_sel_i,
  input  logic [BYTE_W-1:0]                 wr_data_i,
  output logic [NUM_CMP-1:0][ADDR_W-1:0]    match_o,
  output logic [NUM_CMP-1:0]                en_o,
  output logic [NUM_CMP-1:0]                ign_o,
  output logic                              step_o
);
  logic [NUM_CMP-1:0][ADDR_W-1:0] match_q;
  logic [CTRL_W-1:0]              ctrl_q;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          match_q[i][b*BYTE_W +: BYTE_W] <= '0;
        else if (wr_en_i && wr_sel_i == SEL_W'(i*NBYTES + b))
          match_q[i][b*BYTE_W +: BYTE_W] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      ctrl_q <= '0;
    else if (wr_en_i && wr_sel_i == SEL_W'(CTRL_SEL))
      ctrl_q <= wr_data_i[CTRL_W-1:0];
  end

  assign match_o = match_q;
  assign step_o  = ctrl_q[STEP_BIT];
  assign ign_o   = ctrl_q[IGN_LSB +: NUM_CMP];
  assign en_o    = ctrl_q[EN_LSB +: NUM_CMP];

  p_ctrl_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_W'(CTRL_SEL)) |=>
      ({en_o, ign_o, step_o} == $past(wr_data_i[CTRL_W-1:0])));

  p_match_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(match_o));
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              vld_i,
  input  logic              en_i,
  input  logic              ign_i,
  input  logic [ADDR_W-1:0] match_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] mask;
  logic              eq;

  // page mode drops the low byte from the compare
  assign mask  = ign_i ? {{(ADDR_W-BYTE_W){1'b1}}, {BYTE_W{1'b0}}} : '1;
  assign eq    = ((addr_i ^ match_i) & mask) == '0;
  assign hit_o = vld_i & en_i & eq;

  p_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (en_i && vld_i));

  p_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !ign_i) |-> (addr_i == match_i));

  p_page_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (addr_i[ADDR_W-1:BYTE_W] == match_i[ADDR_W-1:BYTE_W]));
endmodule

// File: rtl/bkpt_flag.sv
module bkpt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic brk_o
);
  logic brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     brk_q <= 1'b0;
    else if (set_i)  brk_q <= 1'b1;   // set beats clear
    else if (clr_i)  brk_q <= 1'b0;
  end

  assign brk_o = brk_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_o && !clr_i) |=> brk_o);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !brk_o);

  p_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> brk_o);
endmodule

// File: rtl/addr_bkpt.sv
module addr_bkpt
  import bkpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  input  logic              insn_done_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              brk_clr_i,
  output logic              brk_o
);
  logic [NUM_CMP-1:0][ADDR_W-1:0] match;
  logic [NUM_CMP-1:0]             en, ign, hit;
  logic                           step_en, step_hit, set;

  bkpt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .match_o   (match),
    .en_o      (en),
    .ign_o     (ign),
    .step_o    (step_en)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    bkpt_cmp u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (addr_i),
      .vld_i   (addr_vld_i),
      .en_i    (en[i]),
      .ign_i   (ign[i]),
      .match_i (match[i]),
      .hit_o   (hit[i])
    );
  end

  assign step_hit = insn_done_i & step_en;
  assign set      = (|hit) | step_hit;

  bkpt_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (brk_clr_i),
    .brk_o  (brk_o)
  );

  p_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_done_i && step_en) |=> brk_o);

  p_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_vld_i && !insn_done_i && (!brk_o || brk_clr_i)) |=> !brk_o);
endmodule

// File: tb/tb_addr_bkpt.sv
`timescale 1ns/1ps
module tb_addr_bkpt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        vld = 1'b0, done = 1'b0, wr = 1'b0, clr = 1'b0;
  logic [2:0]  sel = '0;
  logic [7:0]  data = '0;
  logic        brk;

  int total = 0, bad = 0;
  bit finished = 0;

  bit    exp_q[$];
  string tag_q[$];

  // bench model
  logic [23:0] m_match [2];
  logic [7:0]  m_ctrl;
  logic        m_brk;

  always #2 clk = ~clk;

  addr_bkpt dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .addr_vld_i(vld),
    .insn_done_i(done), .wr_en_i(wr), .wr_sel_i(sel), .wr_data_i(data),
    .brk_clr_i(clr), .brk_o(brk)
  );

  task automatic cyc(input logic [23:0] a, input logic v, input logic d,
                     input logic w, input logic [2:0] s, input logic [7:0] dt,
                     input logic c, input string tag);
    logic set;
    @(negedge clk);
    addr = a; vld = v; done = d; wr = w; sel = s; data = dt; clr = c;
    set = 1'b0;
    for (int i = 0; i < 2; i++) begin
      if (v && m_ctrl[3+i]) begin
        if (m_ctrl[1+i]) begin
          if (a[23:8] == m_match[i][23:8]) set = 1'b1;
        end else if (a == m_match[i]) set = 1'b1;
      end
    end
    if (d && m_ctrl[0]) set = 1'b1;
    m_brk = set | (m_brk & ~c);
    exp_q.push_back(m_brk);
    tag_q.push_back(tag);
    if (w) begin
      if (s == 3'd6) m_ctrl = dt;
      else if (s < 3'd3) m_match[0][s*8 +: 8] = dt;
      else if (s < 3'd6) m_match[1][(s-3)*8 +: 8] = dt;
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [7:0] dt, input string tag);
    cyc(24'h0, 0, 0, 1, s, dt, 0, tag);
  endtask

  task automatic look(input logic [23:0] a, input string tag);
    cyc(a, 1, 0, 0, 3'd0, 8'h0, 0, tag);
  endtask

  task automatic idle(input logic c, input string tag);
    cyc(24'h0, 0, 0, 0, 3'd0, 8'h0, c, tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        bit e; string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (brk !== e) begin
          bad++;
          $display("FAIL %s: brk_o=%0b expected=%0b", t, brk, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_match[0] = '0; m_match[1] = '0; m_ctrl = '0; m_brk = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (brk !== 1'b0) begin bad++; $display("FAIL R1 reset: brk_o=%0b expected=0", brk); end
    @(negedge clk); rst_n = 1'b1;

    // R1: zeroed registers raise nothing
    cyc(24'h000000, 1, 1, 0, 3'd0, 8'h0, 0, "R1 zero regs");
    // R10 map, R4 disabled comparator
    wreg(3'd0, 8'h56, "R10 wr lo0");
    wreg(3'd1, 8'h34, "R10 wr hi0");
    wreg(3'd2, 8'h12, "R10 wr up0");
    look(24'h123456, "R4 disabled cmp0");
    wreg(3'd6, 8'h08, "R10 en0");
    look(24'h123456, "R2 full match");
    idle(0, "R8 hold");
    idle(1, "R8 clear");
    idle(0, "R8 stays clear");
    look(24'h123457, "R2 low byte differs");
    look(24'h133456, "R2 upper byte differs");
    cyc(24'h123456, 0, 0, 0, 3'd0, 8'h0, 0, "R7 no strobe");
    // R3 page mode on cmp0
    wreg(3'd6, 8'h0A, "R10 en0 ign0");
    look(24'h1234FF, "R3 page hit");
    idle(1, "R8 clear");
    look(24'h123500, "R3 next page miss");
    look(24'h023456, "R3 upper miss");
    // R5 independence
    wreg(3'd3, 8'hEF, "R10 wr lo1");
    wreg(3'd4, 8'hCD, "R10 wr hi1");
    wreg(3'd5, 8'hAB, "R10 wr up1");
    wreg(3'd6, 8'h12, "R10 en1 ign0");
    look(24'hABCD00, "R5 cmp1 exact despite ign0");
    look(24'h123456, "R5 cmp0 off");
    look(24'hABCDEF, "R5 cmp1 hit");
    idle(1, "R8 clear");
    wreg(3'd6, 8'h14, "R10 en1 ign1");
    look(24'hABCD01, "R5 cmp1 page hit");
    idle(1, "R8 clear");
    look(24'h123456, "R5 cmp0 still off");
    wreg(3'd6, 8'h1E, "R10 both en ign");
    look(24'h1234AA, "R5 cmp0 page");
    idle(1, "R8 clear");
    // R6 single step
    wreg(3'd6, 8'h01, "R10 step");
    cyc(24'h123456, 1, 0, 0, 3'd0, 8'h0, 0, "R6 step no done");
    cyc(24'h0, 0, 1, 0, 3'd0, 8'h0, 0, "R6 step break");
    cyc(24'h0, 0, 1, 0, 3'd0, 8'h0, 1, "R8 set beats clear");
    idle(1, "R8 clear");
    wreg(3'd6, 8'h00, "R10 step off");
    cyc(24'h0, 0, 1, 0, 3'd0, 8'h0, 0, "R6 done ignored");
    // R9 write/compare collision
    wreg(3'd6, 8'h08, "R10 en0");
    cyc(24'h123457, 1, 0, 1, 3'd0, 8'h57, 0, "R9 old low byte");
    look(24'h123457, "R9 new low byte");
    idle(1, "R8 clear");
    wreg(3'd6, 8'h00, "R10 all off");
    cyc(24'h123457, 1, 0, 1, 3'd6, 8'h08, 0, "R9 old enable");
    look(24'h123457, "R9 new enable");
    idle(1, "R8 clear");
    repeat (3) @(posedge clk);
    #1;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule